// File: doc/BRIEF.md
# Masked Bit-Test Execution Unit

This unit carries out a single instruction of an 8-bit processor built around a register file: a masked bit test. An opcode byte arrives on a byte-wide input strobe. The one or two operand bytes follow it on the same strobe. The unit decodes which of five operand forms the opcode selects. It then reads a destination value and a mask from its own 256-entry register file, going through one level of indirection when the form calls for it.

The unit ANDs the destination with the mask and updates the status flags. It raises a one-cycle completion pulse in a cycle fixed by the operand form, and reports the instruction length in the same cycle. Neither operand location is written back.

Short register names are 4-bit indices. They are widened to a full address by placing the upper bits of a register pointer above them, and the register pointer is an input. Outside an instruction, side ports preload the register file and the flags, and a combinational peek port reads any register. These ports let the surrounding core, or a test bench, set up and inspect state.

Top module: `tm_exec`

## Requirements
- R1: After synchronous reset, `flags_o` is 0, and `done_o`, `illegal_o` and `busy_o` are low. Flag bit order is [0]=carry, [1]=zero, [2]=sign, [3]=overflow, [4]=decimal-adjust, [5]=half-carry.
- R2: At completion, zero is 1 exactly when (destination AND mask) is 0, and sign equals bit 7 of that AND.
- R3: At completion, overflow is 0, and carry, decimal-adjust and half-carry keep the values they had before the instruction.
- R4: Opcodes 72h and 73h take one operand byte. Its bits [7:4] name the destination short register and bits [3:0] name the source short register. A short register n maps to address {rp_bank_i, n}.
- R5: Opcodes 74h, 75h and 76h take two operand bytes: the first is the source, the second is the destination address. For 76h, the first operand byte is itself the mask.
- R6: For 73h and 75h, the source register holds an address, and the mask is the content of the register at that address.
- R7: Counting the opcode cycle as cycle 1, with operand bytes on consecutive cycles, `done_o` is high in cycle 4 for 72h and in cycle 6 for the other four opcodes. Each cycle in which an expected operand byte is missing adds one cycle. `done_o` lasts one cycle, and `ilen_o` is 2 or 3 with it.
- R8: A byte accepted while idle that is outside 72h..76h raises `illegal_o` for exactly the next cycle. It changes neither the flags nor the register file, and the unit stays idle.
- R9: The register file and the flags change through the load ports only while `busy_o` is low. A load requested while busy is dropped. No instruction writes the register file.
- R10: `busy_o` is high from the cycle after a legal opcode up to, but not including, the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Instruction byte strobe |
| in_byte_i | input | 8 | Instruction byte (opcode when idle, operand otherwise) |
| rp_bank_i | input | 4 | Upper address bits for short register names |
| rf_ld_i | input | 1 | Register file load request (honoured while idle) |
| rf_ld_addr_i | input | 8 | Register file load address |
| rf_ld_data_i | input | 8 | Register file load data |
| flg_ld_i | input | 1 | Flag load request (honoured while idle) |
| flg_ld_val_i | input | 6 | Flag load value |
| peek_addr_i | input | 8 | Register file peek address |
| peek_data_o | output | 8 | Register file content at peek address |
| flags_o | output | 6 | Status flags |
| done_o | output | 1 | Completion pulse |
| ilen_o | output | 2 | Instruction length in bytes, valid with done |
| illegal_o | output | 1 | Unknown opcode pulse |
| busy_o | output | 1 | Instruction in progress |

## Verification
The bench builds the unit with its default parameters: an 8-bit address, 8-bit data and a 4-bit short-register index. These defaults place a full 256-entry file behind the unit. As a result, low direct addresses such as 00h..02h and a high short-register bank such as C0h..C2h or 50h..5Fh can hold distinct values side by side. This separation lets a wrong address mapping, a dropped indirection or a swapped operand order each produce a visibly different flag result.

// File: rtl/tm_pkg.sv
package tm_pkg;

    localparam logic [7:0] OPC_SS  = 8'h72;  // short, short
    localparam logic [7:0] OPC_SSI = 8'h73;  // short, short indirect
    localparam logic [7:0] OPC_FF  = 8'h74;  // full, full
    localparam logic [7:0] OPC_FFI = 8'h75;  // full, full indirect
    localparam logic [7:0] OPC_FK  = 8'h76;  // full, constant

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } seq_e;

    typedef struct packed {
        logic h;
        logic d;
        logic v;
        logic s;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic       legal;
        logic       short_form;
        logic       indirect;
        logic       constant;
        logic [2:0] cycles;
    } dec_t;

endpackage

// File: rtl/tm_decode.sv
module tm_decode
    import tm_pkg::*;
(
    input  logic [7:0] opc_i,
    output dec_t       dec_o
);
    always_comb begin
        dec_o = '0;
        unique case (opc_i)
            OPC_SS:  dec_o = '{legal: 1'b1, short_form: 1'b1, indirect: 1'b0, constant: 1'b0, cycles: 3'd4};
            OPC_SSI: dec_o = '{legal: 1'b1, short_form: 1'b1, indirect: 1'b1, constant: 1'b0, cycles: 3'd6};
            OPC_FF:  dec_o = '{legal: 1'b1, short_form: 1'b0, indirect: 1'b0, constant: 1'b0, cycles: 3'd6};
            OPC_FFI: dec_o = '{legal: 1'b1, short_form: 1'b0, indirect: 1'b1, constant: 1'b0, cycles: 3'd6};
            OPC_FK:  dec_o = '{legal: 1'b1, short_form: 1'b0, indirect: 1'b0, constant: 1'b1, cycles: 3'd6};
            default: dec_o = '0;
        endcase
    end
endmodule

// File: rtl/tm_regfile.sv
module tm_regfile #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [DW-1:0] rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_b_o,
    input  logic [AW-1:0] raddr_c_i,
    output logic [DW-1:0] rdata_c_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_a_o = mem[raddr_a_i];
    assign rdata_b_o = mem[raddr_b_i];
    assign rdata_c_o = mem[raddr_c_i];
endmodule

// File: rtl/tm_flagcalc.sv
module tm_flagcalc
    import tm_pkg::*;
#(
    parameter int DW = 8
) (
    input  flags_t        prev_i,
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] mask_i,
    output flags_t        next_o
);
    logic [DW-1:0] res;

    always_comb begin
        res    = dst_i & mask_i;
        next_o = prev_i;
        next_o.z = (res == '0);
        next_o.s = res[DW-1];
        next_o.v = 1'b0;
    end
endmodule

// File: rtl/tm_exec.sv
module tm_exec
    import tm_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 8,
    parameter int WR_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid_i,
    input  logic [DW-1:0]      in_byte_i,
    input  logic [AW-WR_W-1:0] rp_bank_i,
    input  logic               rf_ld_i,
    input  logic [AW-1:0]      rf_ld_addr_i,
    input  logic [DW-1:0]      rf_ld_data_i,
    input  logic               flg_ld_i,
    input  logic [5:0]         flg_ld_val_i,
    input  logic [AW-1:0]      peek_addr_i,
    output logic [DW-1:0]      peek_data_o,
    output logic [5:0]         flags_o,
    output logic               done_o,
    output logic [1:0]         ilen_o,
    output logic               illegal_o,
    output logic               busy_o
);
    localparam int CNT_W = 3;

    typedef struct packed {
        seq_e             st;
        dec_t             dec;
        logic [1:0]       bidx;
        logic [DW-1:0]    op1;
        logic [DW-1:0]    op2;
        logic [CNT_W-1:0] cnt;
        logic             ptr_ok;
        logic [AW-1:0]    ind_addr;
        flags_t           flg;
        logic             done;
        logic             illeg;
        logic [1:0]       ilen;
    } state_t;

    state_t q, d;

    dec_t          in_dec;
    logic [AW-1:0] dst_addr;
    logic [AW-1:0] src_addr;
    logic [AW-1:0] rd_b_addr;
    logic [DW-1:0] rd_a;
    logic [DW-1:0] rd_b;
    logic [DW-1:0] mask;
    flags_t        calc_flg;
    logic [1:0]    need;
    logic          rf_we;

    tm_decode u_dec (
        .opc_i (in_byte_i),
        .dec_o (in_dec)
    );

    // operand address formation
    always_comb begin
        if (q.dec.short_form) begin
            dst_addr = {rp_bank_i, q.op1[DW-1 -: WR_W]};
            src_addr = {rp_bank_i, q.op1[WR_W-1:0]};
        end else begin
            dst_addr = AW'(q.op2);
            src_addr = AW'(q.op1);
        end
        rd_b_addr = (q.dec.indirect && q.ptr_ok) ? q.ind_addr : src_addr;
        mask      = q.dec.constant ? q.op1 : rd_b;
        need      = q.dec.short_form ? 2'd1 : 2'd2;
    end

    assign rf_we = rf_ld_i && (q.st == ST_IDLE);

    tm_regfile #(.AW(AW), .DW(DW)) u_rf (
        .clk       (clk),
        .we_i      (rf_we),
        .waddr_i   (rf_ld_addr_i),
        .wdata_i   (rf_ld_data_i),
        .raddr_a_i (dst_addr),
        .rdata_a_o (rd_a),
        .raddr_b_i (rd_b_addr),
        .rdata_b_o (rd_b),
        .raddr_c_i (peek_addr_i),
        .rdata_c_o (peek_data_o)
    );

    tm_flagcalc #(.DW(DW)) u_flg (
        .prev_i (q.flg),
        .dst_i  (rd_a),
        .mask_i (mask),
        .next_o (calc_flg)
    );

    // next-state computation
    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.illeg = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (flg_ld_i) begin
                    d.flg = flags_t'(flg_ld_val_i);
                end
                if (in_valid_i) begin
                    if (in_dec.legal) begin
                        d.st     = ST_FETCH;
                        d.dec    = in_dec;
                        d.cnt    = CNT_W'(1);
                        d.bidx   = 2'd0;
                        d.ptr_ok = 1'b0;
                    end else begin
                        d.illeg = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                if (in_valid_i) begin
                    d.cnt  = q.cnt + CNT_W'(1);
                    d.bidx = q.bidx + 2'd1;
                    if (q.bidx == 2'd0) begin
                        d.op1 = in_byte_i;
                    end else begin
                        d.op2 = in_byte_i;
                    end
                    if ((q.bidx + 2'd1) == need) begin
                        d.st = ST_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == (q.dec.cycles - 3'd2)) begin
                    d.done = 1'b1;
                    d.flg  = calc_flg;
                    d.ilen = q.dec.short_form ? 2'd2 : 2'd3;
                    d.st   = ST_IDLE;
                end else if (q.dec.indirect && !q.ptr_ok) begin
                    d.ind_addr = AW'(rd_b);
                    d.ptr_ok   = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign flags_o   = q.flg;
    assign done_o    = q.done;
    assign ilen_o    = q.ilen;
    assign illegal_o = q.illeg;
    assign busy_o    = (q.st != ST_IDLE);
endmodule

// File: rtl/tm_exec_chk.sv
module tm_exec_chk (
    input logic       clk,
    input logic       rst,
    input logic       flg_ld_i,
    input logic [5:0] flags_o,
    input logic       done_o,
    input logic [1:0] ilen_o,
    input logic       illegal_o,
    input logic       busy_o
);
    // R7: completion lasts a single cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: length reported with completion
    assert_done_len_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ilen_o == 2'd2 || ilen_o == 2'd3));

    // R3: overflow cleared on completion
    assert_v_clear_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !flags_o[3]);

    // R3: carry, decimal-adjust, half-carry preserved
    assert_cdh_keep_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (flags_o[0] == $past(flags_o[0]) &&
                    flags_o[4] == $past(flags_o[4]) &&
                    flags_o[5] == $past(flags_o[5])));

    // R8: unknown opcode leaves flags alone and unit idle
    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (illegal_o && !$past(flg_ld_i)) |-> ($stable(flags_o) && !busy_o));

    // R8: illegal and done never together
    assert_no_mix_R8: assert property (@(posedge clk) disable iff (rst)
        !(illegal_o && done_o));

    // R9: flags move only by completion or an idle load
    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !$past(flg_ld_i)) |-> $stable(flags_o));

    // R10: busy is low in the completion cycle
    assert_busy_done_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

bind tm_exec tm_exec_chk u_tm_exec_chk (
    .clk       (clk),
    .rst       (rst),
    .flg_ld_i  (flg_ld_i),
    .flags_o   (flags_o),
    .done_o    (done_o),
    .ilen_o    (ilen_o),
    .illegal_o (illegal_o),
    .busy_o    (busy_o)
);

// File: tb/test_tm_exec.sv
module test_tm_exec;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_byte_i = '0;
    logic [3:0] rp_bank_i = 4'hC;
    logic       rf_ld_i = 1'b0;
    logic [7:0] rf_ld_addr_i = '0;
    logic [7:0] rf_ld_data_i = '0;
    logic       flg_ld_i = 1'b0;
    logic [5:0] flg_ld_val_i = '0;
    logic [7:0] peek_addr_i = '0;
    logic [7:0] peek_data_o;
    logic [5:0] flags_o;
    logic       done_o;
    logic [1:0] ilen_o;
    logic       illegal_o;
    logic       busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tm_exec i_tm_exec (
        .clk          (clk),
        .rst          (rst),
        .in_valid_i   (in_valid_i),
        .in_byte_i    (in_byte_i),
        .rp_bank_i    (rp_bank_i),
        .rf_ld_i      (rf_ld_i),
        .rf_ld_addr_i (rf_ld_addr_i),
        .rf_ld_data_i (rf_ld_data_i),
        .flg_ld_i     (flg_ld_i),
        .flg_ld_val_i (flg_ld_val_i),
        .peek_addr_i  (peek_addr_i),
        .peek_data_o  (peek_data_o),
        .flags_o      (flags_o),
        .done_o       (done_o),
        .ilen_o       (ilen_o),
        .illegal_o    (illegal_o),
        .busy_o       (busy_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic rf_load(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        rf_ld_i = 1'b1; rf_ld_addr_i = a; rf_ld_data_i = v;
        @(negedge clk);
        rf_ld_i = 1'b0;
    endtask

    task automatic flg_load(input logic [5:0] v);
        @(negedge clk);
        flg_ld_i = 1'b1; flg_ld_val_i = v;
        @(negedge clk);
        flg_ld_i = 1'b0;
    endtask

    task automatic peek_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        peek_addr_i = a;
        #1;
        check(tag, peek_data_o, exp);
    endtask

    // runs one instruction; gap = idle cycles before the first operand byte
    task automatic run_tm(input string tag, input logic [7:0] opc, input logic [7:0] b2,
                          input logic [7:0] b3, input int nb, input int gap,
                          input int exp_cyc, input logic exp_z, input logic exp_s);
        logic [5:0] prev;
        logic [5:0] expf;
        int cyc;
        int sent;
        int waited;
        bit seen;
        @(negedge clk);
        prev = flags_o;
        in_valid_i = 1'b1; in_byte_i = opc;
        cyc = 1; sent = 1; waited = 0; seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cyc++;
            if (cyc == 2) check({tag, " R10 busy"}, busy_o, 1'b1);
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            if (sent < nb && waited < gap) begin
                in_valid_i = 1'b0;
                waited++;
            end else if (sent < nb) begin
                in_valid_i = 1'b1;
                in_byte_i = (sent == 1) ? b2 : b3;
                sent++;
            end else begin
                in_valid_i = 1'b0;
            end
        end
        in_valid_i = 1'b0;
        expf = {prev[5], prev[4], 1'b0, exp_s, exp_z, prev[0]};
        check({tag, " R7 done seen"}, seen, 1'b1);
        check({tag, " R7 done cycle"}, cyc, exp_cyc);
        check({tag, " R7 ilen"}, ilen_o, nb);
        check({tag, " R2/R3 flags"}, flags_o, expf);
        check({tag, " R10 not busy at done"}, busy_o, 1'b0);
        @(negedge clk);
        check({tag, " R7 done one cycle"}, done_o, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 flags", flags_o, 6'h00);
        check("R1 done", done_o, 1'b0);
        check("R1 illegal", illegal_o, 1'b0);
        check("R1 busy", busy_o, 1'b0);
    endtask

    task automatic t_setup();
        rf_load(8'hC0, 8'hC7);
        rf_load(8'hC1, 8'h02);
        rf_load(8'hC2, 8'h18);
        rf_load(8'h00, 8'h2B);
        rf_load(8'h01, 8'h02);
        rf_load(8'h02, 8'h23);
        rf_load(8'h53, 8'hF0);
        rf_load(8'h5A, 8'h30);
        rf_load(8'h03, 8'h0F);
        rf_load(8'h0A, 8'h0F);
        rf_load(8'h30, 8'h00);
    endtask

    task automatic t_vectors();
        run_tm("R4 72 short C7&02", 8'h72, 8'h01, 8'h00, 2, 0, 4, 1'b0, 1'b0);
        run_tm("R6 73 short ind C7&23", 8'h73, 8'h01, 8'h00, 2, 0, 6, 1'b0, 1'b0);
        run_tm("R5 74 full 2B&02", 8'h74, 8'h01, 8'h00, 3, 0, 6, 1'b0, 1'b0);
        run_tm("R6 75 full ind 2B&23", 8'h75, 8'h01, 8'h00, 3, 0, 6, 1'b0, 1'b0);
        run_tm("R5 76 const 2B&54", 8'h76, 8'h54, 8'h00, 3, 0, 6, 1'b1, 1'b0);
        run_tm("R2 76 sign C7&80", 8'h76, 8'h80, 8'hC0, 3, 0, 6, 1'b0, 1'b1);
    endtask

    task automatic t_bank();
        rp_bank_i = 4'h5;
        run_tm("R4 bank 5 F0&30", 8'h72, 8'h3A, 8'h00, 2, 0, 4, 1'b0, 1'b0);
        rp_bank_i = 4'hC;
    endtask

    task automatic t_preserve();
        flg_load(6'h3F);
        check("R9 flag load idle", flags_o, 6'h3F);
        run_tm("R3 keep C/D/H", 8'h74, 8'h01, 8'h00, 3, 0, 6, 1'b0, 1'b0);
        check("R3 flags value", flags_o, 6'h31);
    endtask

    task automatic t_stall();
        run_tm("R7 stall short", 8'h72, 8'h01, 8'h00, 2, 2, 6, 1'b0, 1'b0);
        run_tm("R7 stall full", 8'h76, 8'h54, 8'h00, 3, 1, 7, 1'b1, 1'b0);
    endtask

    task automatic t_illegal(input logic [7:0] opc);
        logic [5:0] prev;
        @(negedge clk);
        prev = flags_o;
        in_valid_i = 1'b1; in_byte_i = opc;
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R8 illegal pulse", illegal_o, 1'b1);
        check("R8 stays idle", busy_o, 1'b0);
        check("R8 flags kept", flags_o, prev);
        @(negedge clk);
        check("R8 pulse ends", illegal_o, 1'b0);
        check("R8 flags still kept", flags_o, prev);
    endtask

    task automatic t_busy_loads();
        logic [5:0] prev;
        @(negedge clk);
        prev = flags_o;
        in_valid_i = 1'b1; in_byte_i = 8'h76;
        @(negedge clk);
        in_byte_i = 8'h54;
        @(negedge clk);
        in_byte_i = 8'h00;
        @(negedge clk);
        in_valid_i = 1'b0;
        rf_ld_i = 1'b1; rf_ld_addr_i = 8'h00; rf_ld_data_i = 8'hFF;
        flg_ld_i = 1'b1; flg_ld_val_i = 6'h3F;
        check("R9 busy during load", busy_o, 1'b1);
        @(negedge clk);
        rf_ld_i = 1'b0; flg_ld_i = 1'b0;
        @(negedge clk);
        check("R9 done after dropped load", done_o, 1'b1);
        check("R9 flags ignore busy load", flags_o, {prev[5], prev[4], 1'b0, 1'b0, 1'b1, prev[0]});
        peek_chk("R9 rf ignores busy load", 8'h00, 8'h2B);
    endtask

    task automatic t_no_write();
        peek_chk("R9 C0 intact", 8'hC0, 8'hC7);
        peek_chk("R9 C1 intact", 8'hC1, 8'h02);
        peek_chk("R9 01 intact", 8'h01, 8'h02);
        peek_chk("R9 02 intact", 8'h02, 8'h23);
        peek_chk("R9 53 intact", 8'h53, 8'hF0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setup();
        t_vectors();
        t_bank();
        t_preserve();
        t_stall();
        t_illegal(8'h71);
        t_illegal(8'h77);
        t_busy_loads();
        t_no_write();
        summary();
    end
endmodule